// File: doc/BRIEF.md
# Multi-Mode External Interrupt Front End

This block sits between eight active-low external interrupt request pins, one active-low non-maskable request pin, and a processor core. It brings every pin into the core clock domain, detects low levels and falling edges, holds edge-triggered requests until the core acknowledges them, and presents one request at a time as a valid flag, an 8-bit vector and a non-maskable flag.

A two-bit mode input decides how the eight request pins are read. In dedicated operation every pin is its own source with a fixed vector, and each pin can be set to level or edge sensing. In expanded operation the eight pins together are one level-sensitive vector. In mixed operation the top three pins stay dedicated and the low five pins give the upper bits of a vector whose lowest three bits are filled in internally. The non-maskable pin is falling-edge triggered in every mode and always outranks everything else.

The core acknowledges a presented request with a one-cycle `ack` pulse. The pulse names either the non-maskable source or a dedicated pin index. Changing the mode drops all edge requests captured under the old pin mapping.

Top module: `irq_front`

## Requirements
- R1: Every pin passes through a two-flop synchroniser that resets to the inactive-high value, and after reset `irq_valid` and `irq_nmi` are 0.
- R2: `mode` encoding: 2'b00 dedicated, 2'b01 expanded, 2'b10 mixed. 2'b11 behaves exactly like dedicated.
- R3: A pending dedicated source on pin i presents vector 8'h12 + 16*i (pin 0 gives 8'h12, pin 7 gives 8'h82). When several dedicated sources are pending, the highest pin index is presented.
- R4: A dedicated pin with `edge_sel[i]`=1 latches on a falling edge. The latch stays pending after the pin returns high, until an `ack` with `ack_nmi`=0 and `ack_idx`=i. An acknowledge for another index leaves it pending.
- R5: A dedicated pin with `edge_sel[i]`=0 requests only while its synchronised level is low, and `ack` has no effect on it.
- R6: In expanded mode, `irq_vec` is the bitwise inverse of the eight pins, and `irq_valid` is 1 exactly when any pin is low. `edge_sel` is ignored and nothing is latched.
- R7: In mixed mode, pins 7..5 behave as dedicated sources under R3 to R5. Pins 4..0 form the vector {~pins[4:0], 3'b010}, which requests while any of those five pins is low. A pending dedicated source is presented ahead of this vector.
- R8: A falling edge on `nmi_n` sets a pending flag. While it is pending, `irq_nmi`=1, `irq_valid`=1 and `irq_vec`=8'hF8, ahead of all other sources. Only an `ack` with `ack_nmi`=1 clears it, and holding `nmi_n` low does not set it again.
- R9: Any change of `mode` clears every dedicated edge latch on the next clock edge. A pending non-maskable request is kept.
- R10: A level request shows at the outputs after the second rising edge that follows the pin falling. An edge request shows after the third.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_n | input | 8 | Active-low external request pins |
| nmi_n | input | 1 | Active-low non-maskable request pin, falling-edge triggered |
| mode | input | 2 | Pin mapping: 00 dedicated, 01 expanded, 10 mixed, 11 as dedicated |
| edge_sel | input | 8 | Per-pin sensing for dedicated pins: 1 falling edge, 0 low level |
| ack | input | 1 | One-cycle acknowledge pulse from the core |
| ack_nmi | input | 1 | With `ack`: 1 acknowledges the non-maskable request |
| ack_idx | input | 3 | With `ack` and `ack_nmi`=0: dedicated pin index being acknowledged |
| irq_valid | output | 1 | A request is presented |
| irq_vec | output | 8 | Vector of the presented request |
| irq_nmi | output | 1 | The presented request is the non-maskable one |

## Verification
A stuck or stale edge latch shows at the ports as a vector that persists after the pin has returned high and after an acknowledge or a mode change. It becomes visible one edge after the acknowledge or mode switch that should have removed it. A wrong mode decode shows at once as a vector with the wrong layout, for example missing the 3'b010 fill or showing a dedicated code in expanded mode. Synchroniser depth errors move the appearance of a request earlier or later than the second or third edge. The directed scenarios sample exactly at those edges.

// File: rtl/irq_front_pkg.sv
package irq_front_pkg;
   typedef enum logic [1:0] {
      MODE_DED = 2'b00,
      MODE_EXP = 2'b01,
      MODE_MIX = 2'b10,
      MODE_ALT = 2'b11
   } irq_mode_e;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("irq_sync needs at least two stages");
   end

   logic [W-1:0] stg [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stg[s] <= '1;
         else if (s == 0) stg[s] <= d;
         else stg[s] <= stg[(s == 0) ? 0 : s-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/irq_pend.sv
module irq_pend #(
   parameter int N = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] lines_s,
   input  logic [N-1:0] ded_mask,
   input  logic [N-1:0] edge_sel,
   input  logic [N-1:0] ack_hit,
   input  logic         flush,
   output logic [N-1:0] ded_req,
   output logic [N-1:0] pend_q
);
   logic [N-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '1;
      else prev_q <= lines_s;
   end

   for (genvar i = 0; i < N; i++) begin : g_line
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pend_q[i] <= 1'b0;
         else if (flush) pend_q[i] <= 1'b0;
         else if (!(ded_mask[i] && edge_sel[i])) pend_q[i] <= 1'b0;
         else if (prev_q[i] && !lines_s[i]) pend_q[i] <= 1'b1;
         else if (ack_hit[i]) pend_q[i] <= 1'b0;
      end
      assign ded_req[i] = ded_mask[i] & (edge_sel[i] ? pend_q[i] : ~lines_s[i]);
   end
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
   parameter int N        = 8,
   parameter int DED_BASE = 8'h12,
   parameter int DED_STEP = 8'h10,
   parameter int NMI_VEC  = 8'hF8
) (
   input  logic         nmi_pend,
   input  logic [N-1:0] ded_req,
   input  logic         vec_req,
   input  logic [N-1:0] vec_val,
   output logic         valid,
   output logic [N-1:0] vec,
   output logic         nmi
);
   logic [N-1:0] ded_vec;

   always_comb begin
      ded_vec = '0;
      for (int i = 0; i < N; i++) begin
         if (ded_req[i]) ded_vec = N'(DED_BASE + i * DED_STEP);
      end
   end

   always_comb begin
      valid = 1'b0;
      vec   = '0;
      nmi   = 1'b0;
      if (nmi_pend) begin
         valid = 1'b1;
         nmi   = 1'b1;
         vec   = N'(NMI_VEC);
      end else if (|ded_req) begin
         valid = 1'b1;
         vec   = ded_vec;
      end else if (vec_req) begin
         valid = 1'b1;
         vec   = vec_val;
      end
   end
endmodule

// File: rtl/irq_front.sv
module irq_front #(
   parameter int                 NUM_LINES = 8,
   parameter int                 MIX_DED   = 3,
   parameter logic [MIX_DED-1:0] MIX_FILL  = 3'b010,
   parameter int                 SYNC_STG  = 2,
   parameter int                 DED_BASE  = 8'h12,
   parameter int                 DED_STEP  = 8'h10,
   parameter int                 NMI_VEC   = 8'hF8,
   localparam int                IDX_W     = $clog2(NUM_LINES)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] req_n,
   input  logic                 nmi_n,
   input  logic [1:0]           mode,
   input  logic [NUM_LINES-1:0] edge_sel,
   input  logic                 ack,
   input  logic                 ack_nmi,
   input  logic [IDX_W-1:0]     ack_idx,
   output logic                 irq_valid,
   output logic [NUM_LINES-1:0] irq_vec,
   output logic                 irq_nmi
);
   import irq_front_pkg::*;

   localparam int VW = NUM_LINES - MIX_DED;
   localparam logic [NUM_LINES-1:0] MIX_MASK = {{MIX_DED{1'b1}}, {VW{1'b0}}};

   if (NUM_LINES < 2 || (1 << IDX_W) != NUM_LINES) begin : g_bad_lines
      $error("NUM_LINES must be a power of two of at least 2");
   end
   if (MIX_DED < 1 || MIX_DED >= NUM_LINES) begin : g_bad_mix
      $error("MIX_DED must leave at least one vectored pin");
   end

   logic [NUM_LINES:0]   all_s;
   logic [NUM_LINES-1:0] line_s, act, ded_mask, ack_hit, ded_req, pend_q, vec_val;
   logic                 nmi_s, nmi_prev, nmi_pend, vec_req, flush;
   irq_mode_e            mode_e, mode_q;

   irq_sync #(.W(NUM_LINES + 1), .STAGES(SYNC_STG)) u_sync (
      .clk(clk), .rst_n(rst_n), .d({nmi_n, req_n}), .q(all_s));

   assign line_s = all_s[NUM_LINES-1:0];
   assign nmi_s  = all_s[NUM_LINES];
   assign act    = ~line_s;
   assign mode_e = irq_mode_e'(mode);
   assign flush  = (mode_e != mode_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mode_q <= MODE_DED;
      else mode_q <= mode_e;
   end

   always_comb begin
      ded_mask = '1;
      vec_req  = 1'b0;
      vec_val  = '0;
      case (mode_e)
         MODE_EXP: begin
            ded_mask = '0;
            vec_req  = |act;
            vec_val  = act;
         end
         MODE_MIX: begin
            ded_mask = MIX_MASK;
            vec_req  = |act[VW-1:0];
            vec_val  = {act[VW-1:0], MIX_FILL};
         end
         default: ded_mask = '1;
      endcase
   end

   assign ack_hit = (ack && !ack_nmi) ? (NUM_LINES'(1) << ack_idx) : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         nmi_prev <= 1'b1;
         nmi_pend <= 1'b0;
      end else begin
         nmi_prev <= nmi_s;
         if (nmi_prev && !nmi_s) nmi_pend <= 1'b1;
         else if (ack && ack_nmi) nmi_pend <= 1'b0;
      end
   end

   irq_pend #(.N(NUM_LINES)) u_pend (
      .clk(clk), .rst_n(rst_n), .lines_s(line_s), .ded_mask(ded_mask),
      .edge_sel(edge_sel), .ack_hit(ack_hit), .flush(flush),
      .ded_req(ded_req), .pend_q(pend_q));

   irq_pick #(.N(NUM_LINES), .DED_BASE(DED_BASE), .DED_STEP(DED_STEP),
              .NMI_VEC(NMI_VEC)) u_pick (
      .nmi_pend(nmi_pend), .ded_req(ded_req), .vec_req(vec_req),
      .vec_val(vec_val), .valid(irq_valid), .vec(irq_vec), .nmi(irq_nmi));
endmodule

// File: rtl/irq_front_chk.sv
module irq_front_chk #(
   parameter int                 NUM_LINES = 8,
   parameter int                 MIX_DED   = 3,
   parameter logic [MIX_DED-1:0] MIX_FILL  = 3'b010,
   parameter int                 NMI_VEC   = 8'hF8
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [1:0]           mode,
   input logic                 ack,
   input logic                 ack_nmi,
   input logic                 irq_valid,
   input logic [NUM_LINES-1:0] irq_vec,
   input logic                 irq_nmi,
   input logic [NUM_LINES-1:0] line_s,
   input logic                 nmi_pend,
   input logic [NUM_LINES-1:0] pend_q,
   input logic                 flush
);
   localparam int VW = NUM_LINES - MIX_DED;

   AST_NMI_ON_TOP: assert property (@(posedge clk) disable iff (!rst_n)
      nmi_pend |-> (irq_nmi && irq_valid && irq_vec == NUM_LINES'(NMI_VEC))); // R8
   AST_NMI_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_nmi && !(ack && ack_nmi)) |=> irq_nmi); // R8
   AST_MODE_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (pend_q == '0)); // R9
   AST_EXP_ANY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b01 && !irq_nmi) |-> (irq_valid == (line_s != '1))); // R6
   AST_EXP_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b01 && irq_valid && !irq_nmi) |-> (irq_vec == ~line_s)); // R6
   AST_MIX_FILL: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b10 && irq_valid && !irq_nmi && pend_q == '0
       && line_s[NUM_LINES-1:VW] == '1) |-> (irq_vec[MIX_DED-1:0] == MIX_FILL)); // R7
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (line_s == '1 && !nmi_pend && pend_q == '0) |-> !irq_valid); // R5
endmodule

bind irq_front irq_front_chk #(
   .NUM_LINES(NUM_LINES), .MIX_DED(MIX_DED), .MIX_FILL(MIX_FILL), .NMI_VEC(NMI_VEC)
) u_chk (
   .clk(clk), .rst_n(rst_n), .mode(mode), .ack(ack), .ack_nmi(ack_nmi),
   .irq_valid(irq_valid), .irq_vec(irq_vec), .irq_nmi(irq_nmi),
   .line_s(line_s), .nmi_pend(nmi_pend), .pend_q(pend_q), .flush(flush)
);

// File: tb/irq_front_bench.sv
module irq_front_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] req_n = 8'hFF;
   logic       nmi_n = 1'b1;
   logic [1:0] mode = 2'b00;
   logic [7:0] edge_sel = 8'h00;
   logic       ack = 1'b0;
   logic       ack_nmi = 1'b0;
   logic [2:0] ack_idx = 3'd0;
   logic       irq_valid, irq_nmi;
   logic [7:0] irq_vec;
   int         checks = 0;
   int         fails = 0;
   bit         done = 1'b0;

   always #10 clk = ~clk;

   irq_front u_irq_front (
      .clk(clk), .rst_n(rst_n), .req_n(req_n), .nmi_n(nmi_n), .mode(mode),
      .edge_sel(edge_sel), .ack(ack), .ack_nmi(ack_nmi), .ack_idx(ack_idx),
      .irq_valid(irq_valid), .irq_vec(irq_vec), .irq_nmi(irq_nmi));

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic expect_out(input string tag, input logic v, input logic [7:0] vec,
                             input logic n);
      checks++;
      if (irq_valid !== v || irq_nmi !== n || (v && irq_vec !== vec)) begin
         fails++;
         $display("FAIL %s: got valid=%0b vec=%02h nmi=%0b, expected valid=%0b vec=%02h nmi=%0b",
                  tag, irq_valid, irq_vec, irq_nmi, v, vec, n);
      end
   endtask

   task automatic do_ack(input logic is_nmi, input logic [2:0] idx);
      ack = 1'b1; ack_nmi = is_nmi; ack_idx = idx;
      step(1);
      ack = 1'b0; ack_nmi = 1'b0;
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      step(3);
      rst_n = 1'b1;
      expect_out("R1 idle after reset", 1'b0, 8'h00, 1'b0);
      step(2);
      expect_out("R1 idle with all pins high", 1'b0, 8'h00, 1'b0);
   endtask

   task automatic t_ded_level();
      mode = 2'b00; edge_sel = 8'h00;
      req_n[3] = 1'b0;
      step(1);
      expect_out("R10 level not visible after one edge", 1'b0, 8'h00, 1'b0);
      step(1);
      expect_out("R10 R5 level pin 3 after two edges", 1'b1, 8'h42, 1'b0);
      req_n[6] = 1'b0;
      step(2);
      expect_out("R3 higher pin 6 wins", 1'b1, 8'h72, 1'b0);
      do_ack(1'b0, 3'd6);
      expect_out("R5 ack ignored on level pin", 1'b1, 8'h72, 1'b0);
      req_n = 8'hFF;
      step(2);
      expect_out("R5 level released", 1'b0, 8'h00, 1'b0);
   endtask

   task automatic t_ded_edge();
      edge_sel = 8'hFF;
      step(1);
      req_n[2] = 1'b0;
      step(2);
      expect_out("R10 edge not visible after two edges", 1'b0, 8'h00, 1'b0);
      step(1);
      expect_out("R10 R4 edge pin 2 after three edges", 1'b1, 8'h32, 1'b0);
      req_n[2] = 1'b1;
      step(4);
      expect_out("R4 edge held after pin high", 1'b1, 8'h32, 1'b0);
      do_ack(1'b0, 3'd5);
      expect_out("R4 other index ack keeps pending", 1'b1, 8'h32, 1'b0);
      do_ack(1'b0, 3'd2);
      expect_out("R4 matching ack clears", 1'b0, 8'h00, 1'b0);
   endtask

   task automatic t_expanded();
      mode = 2'b01;
      req_n = ~8'h5A;
      step(2);
      expect_out("R6 expanded vector", 1'b1, 8'h5A, 1'b0);
      req_n = ~8'h01;
      step(2);
      expect_out("R6 expanded single low pin", 1'b1, 8'h01, 1'b0);
      req_n = 8'hFF;
      step(2);
      expect_out("R6 expanded all high no latch", 1'b0, 8'h00, 1'b0);
   endtask

   task automatic t_mixed();
      mode = 2'b10; edge_sel = 8'h00;
      req_n = 8'hEC;
      step(2);
      expect_out("R7 mixed vector fill 010", 1'b1, 8'h9A, 1'b0);
      req_n[5] = 1'b0;
      step(2);
      expect_out("R7 dedicated pin 5 ahead of vector", 1'b1, 8'h62, 1'b0);
      req_n[7] = 1'b0;
      step(2);
      expect_out("R7 R3 pin 7 wins", 1'b1, 8'h82, 1'b0);
      req_n = 8'hFF;
      step(2);
      expect_out("R7 mixed released", 1'b0, 8'h00, 1'b0);
      edge_sel = 8'h40;
      step(1);
      req_n[6] = 1'b0;
      step(1);
      req_n[6] = 1'b1;
      step(4);
      expect_out("R7 mixed edge pin 6 latched", 1'b1, 8'h72, 1'b0);
      do_ack(1'b0, 3'd6);
      expect_out("R7 mixed edge acked", 1'b0, 8'h00, 1'b0);
   endtask

   task automatic t_nmi();
      mode = 2'b00; edge_sel = 8'h00;
      req_n[1] = 1'b0;
      step(2);
      expect_out("R3 pin 1 level", 1'b1, 8'h22, 1'b0);
      nmi_n = 1'b0;
      step(3);
      expect_out("R8 nmi presented first", 1'b1, 8'hF8, 1'b1);
      do_ack(1'b0, 3'd1);
      expect_out("R8 pin ack leaves nmi", 1'b1, 8'hF8, 1'b1);
      do_ack(1'b1, 3'd0);
      expect_out("R8 nmi ack clears", 1'b1, 8'h22, 1'b0);
      step(3);
      expect_out("R8 held low no retrigger", 1'b1, 8'h22, 1'b0);
      nmi_n = 1'b1; req_n = 8'hFF;
      step(3);
      expect_out("R8 all released", 1'b0, 8'h00, 1'b0);
   endtask

   task automatic t_flush();
      edge_sel = 8'hFF;
      step(1);
      req_n[4] = 1'b0;
      step(1);
      req_n[4] = 1'b1;
      step(3);
      expect_out("R9 setup pin 4 latched", 1'b1, 8'h52, 1'b0);
      nmi_n = 1'b0;
      step(1);
      nmi_n = 1'b1;
      step(3);
      expect_out("R9 setup nmi latched", 1'b1, 8'hF8, 1'b1);
      mode = 2'b01;
      step(1);
      expect_out("R9 nmi kept over mode change", 1'b1, 8'hF8, 1'b1);
      do_ack(1'b1, 3'd0);
      mode = 2'b00;
      step(2);
      expect_out("R9 pin 4 latch flushed", 1'b0, 8'h00, 1'b0);
   endtask

   task automatic t_alt_mode();
      mode = 2'b11; edge_sel = 8'h00;
      req_n[0] = 1'b0;
      step(2);
      expect_out("R2 mode 11 acts dedicated", 1'b1, 8'h12, 1'b0);
      req_n = 8'hFF;
      step(2);
      expect_out("R2 mode 11 released", 1'b0, 8'h00, 1'b0);
   endtask

   initial begin
      t_reset();
      t_ded_level();
      t_ded_edge();
      t_expanded();
      t_mixed();
      t_nmi();
      t_flush();
      t_alt_mode();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog: got timeout, expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end
endmodule